// File: doc/BRIEF.md
# Interrupt Priority Threshold Filter

This block holds a software-loaded priority threshold and uses it to decide which pending external interrupt requests may reach a processor core. Each of up to fifteen request lines carries a fixed priority class, where line `i` has class `i+1`, so class 1 is the lowest and class 15 the highest. A request is recognized only when its class is strictly greater than the threshold. Among the recognized requests, the block reports the single highest class as an encoded value, together with a valid flag, from a registered output stage.

Software loads the threshold through a simple write port and can read it back at any time. The threshold field is the low four bits of a wide register, and every bit above it is reserved and must be zero. A write that sets any reserved bit is refused: the threshold keeps its old value and an error flag rises for one cycle. A threshold of 0 lets every request through, and a threshold of 15 shuts them all out.

Top module: `irq_prio_gate`

## Requirements
- R1: While reset is high, and in the first cycle after it, the threshold reads 0, `irq_valid` is 0, `irq_class` is 0 and `wr_err` is 0.
- R2: A write whose bits 63..4 are all zero loads bits 3..0 into the threshold; from the next cycle `rd_data` returns the threshold in bits 3..0 with bits 63..4 zero.
- R3: A write with any of bits 63..4 set leaves the threshold unchanged and drives `wr_err` high for exactly the next cycle.
- R4: Request line `i` (bit `i` of `req`) has class `i+1`; a request whose class is less than or equal to the threshold is blocked, and one whose class is above it is recognized (threshold 9 passes classes 10 to 15 only).
- R5: With a threshold of 0, every asserted request line is recognized.
- R6: With a threshold of 15, no request is recognized and `irq_valid` stays 0.
- R7: When one or more requests are recognized, `irq_valid` is 1 and `irq_class` is the highest recognized class as an unsigned 4-bit number; when none is, `irq_valid` is 0 and `irq_class` is 0.
- R8: The outputs `irq_valid` and `irq_class` are registered: they reflect `req` and the threshold present before the previous rising edge, so a threshold write changes the decision one cycle after the write cycle.
- R9: `wr_err` is 0 in every cycle that does not follow a refused write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Write data; bits 3..0 threshold, rest reserved |
| rd_data | output | 64 | Current threshold, zero-extended |
| wr_err | output | 1 | One-cycle flag after a refused write |
| req | input | 15 | Request lines, bit i has class i+1 |
| irq_valid | output | 1 | A recognized request exists |
| irq_class | output | 4 | Highest recognized class, 0 when none |

## Verification
The assertions assume reset is high at time zero and is held for at least one rising edge, so that their look-back into the previous cycle always lands on a defined threshold and output state; the bench starts with reset asserted and keeps it for several cycles. They also assume the request lines and the write strobe are stable around each rising edge, which the bench guarantees by changing every input only on the falling edge. Random writes mix legal thresholds with values that set reserved bits, so both the load path and the refusal path are exercised while the reference model tracks the threshold on its own.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   localparam int DEF_REG_W  = 64;
   localparam int DEF_PRIO_W = 4;
   localparam int DEF_NUM_REQ = 15;

   typedef enum logic {
      ENC_SCAN = 1'b0,
      ENC_TREE = 1'b1
   } enc_style_e;
endpackage

// File: rtl/prio_threshold_reg.sv
module prio_threshold_reg #(
   parameter int REG_W  = 64,
   parameter int PRIO_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [PRIO_W-1:0] thr,
   output logic [REG_W-1:0]  rd_data,
   output logic              wr_err
);
   localparam int RSVD_W = REG_W - PRIO_W;

   logic [RSVD_W-1:0] rsvd_bits;
   logic              rsvd_set;
   logic              accept;
   logic [PRIO_W-1:0] thr_q;
   logic              err_q;

   assign rsvd_bits = wr_data[REG_W-1:PRIO_W];
   assign rsvd_set  = |rsvd_bits;
   assign accept    = wr_en & ~rsvd_set;

   always_ff @(posedge clk) begin
      if (rst) begin
         thr_q <= '0;
         err_q <= 1'b0;
      end else begin
         if (accept) thr_q <= wr_data[PRIO_W-1:0];
         err_q <= wr_en & rsvd_set;
      end
   end

   assign thr     = thr_q;
   assign wr_err  = err_q;
   assign rd_data = {{RSVD_W{1'b0}}, thr_q};

   // R2: a clean write lands in the threshold
   p_load_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[REG_W-1:PRIO_W] == '0) |=> thr_q == $past(wr_data[PRIO_W-1:0]));

   // R3: refused write keeps the old value
   p_keep_on_rsvd_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[REG_W-1:PRIO_W] != '0) |=> $stable(thr_q));

   // R3: refused write raises the flag
   p_err_raise_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[REG_W-1:PRIO_W] != '0) |=> err_q);

   // R9: no flag without a refused write
   p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_data[REG_W-1:PRIO_W] != '0) |=> !err_q);
endmodule

// File: rtl/prio_mask.sv
module prio_mask #(
   parameter int NUM_REQ = 15,
   parameter int PRIO_W  = 4
) (
   input  logic [PRIO_W-1:0]  thr,
   input  logic [NUM_REQ-1:0] req,
   output logic [NUM_REQ-1:0] pass
);
   for (genvar i = 0; i < NUM_REQ; i++) begin : g_line
      localparam logic [PRIO_W-1:0] LINE_CLASS = PRIO_W'(i + 1);
      assign pass[i] = req[i] & (LINE_CLASS > thr);
   end
endmodule

// File: rtl/prio_pick.sv
module prio_pick
   import irq_prio_pkg::*;
#(
   parameter int         NUM_REQ = 15,
   parameter int         PRIO_W  = 4,
   parameter enc_style_e ENC     = ENC_TREE
) (
   input  logic [NUM_REQ-1:0] pass,
   output logic               any,
   output logic [PRIO_W-1:0]  cls
);
   localparam int PAD = 1 << PRIO_W;

   if (ENC == ENC_SCAN) begin : g_scan
      always_comb begin
         any = 1'b0;
         cls = '0;
         for (int i = 0; i < NUM_REQ; i++) begin
            if (pass[i]) begin
               any = 1'b1;
               cls = PRIO_W'(i + 1);
            end
         end
      end
   end else begin : g_tree
      for (genvar l = 0; l <= PRIO_W; l++) begin : g_lvl
         localparam int W = PAD >> l;
         logic [W-1:0]      v;
         logic [PRIO_W-1:0] c [W];
         if (l == 0) begin : g_leaf
            for (genvar j = 0; j < W; j++) begin : g_j
               if (j < NUM_REQ) begin : g_real
                  assign v[j] = pass[j];
               end else begin : g_pad
                  assign v[j] = 1'b0;
               end
               assign c[j] = PRIO_W'(j + 1);
            end
         end else begin : g_node
            for (genvar n = 0; n < W; n++) begin : g_n
               assign v[n] = g_lvl[l-1].v[2*n] | g_lvl[l-1].v[2*n+1];
               assign c[n] = g_lvl[l-1].v[2*n+1] ? g_lvl[l-1].c[2*n+1]
                                                 : g_lvl[l-1].c[2*n];
            end
         end
      end
      assign any = g_lvl[PRIO_W].v[0];
      assign cls = g_lvl[PRIO_W].v[0] ? g_lvl[PRIO_W].c[0] : '0;
   end

   // R7: the reported class belongs to a passing line
   always_comb begin
      if (any) a_pick_real_r7: assert (cls != '0 && pass[cls - 1'b1]);
   end
endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate
   import irq_prio_pkg::*;
#(
   parameter int         REG_W   = DEF_REG_W,
   parameter int         PRIO_W  = DEF_PRIO_W,
   parameter int         NUM_REQ = DEF_NUM_REQ,
   parameter enc_style_e ENC     = ENC_TREE
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wr_data,
   output logic [REG_W-1:0]   rd_data,
   output logic               wr_err,
   input  logic [NUM_REQ-1:0] req,
   output logic               irq_valid,
   output logic [PRIO_W-1:0]  irq_class
);
   localparam logic [PRIO_W-1:0] THR_MAX = {PRIO_W{1'b1}};

   if (PRIO_W < 1) begin : g_bad_prio
      $error("PRIO_W must be at least 1");
   end
   if (NUM_REQ < 1 || NUM_REQ > (1 << PRIO_W) - 1) begin : g_bad_req
      $error("NUM_REQ must lie in 1 .. 2**PRIO_W-1");
   end
   if (REG_W <= PRIO_W) begin : g_bad_reg
      $error("REG_W must exceed PRIO_W");
   end

   logic [PRIO_W-1:0]  thr;
   logic [NUM_REQ-1:0] pass;
   logic               any_c;
   logic [PRIO_W-1:0]  cls_c;
   logic               valid_q;
   logic [PRIO_W-1:0]  class_q;

   prio_threshold_reg #(.REG_W(REG_W), .PRIO_W(PRIO_W)) u_thr (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .thr     (thr),
      .rd_data (rd_data),
      .wr_err  (wr_err)
   );

   prio_mask #(.NUM_REQ(NUM_REQ), .PRIO_W(PRIO_W)) u_mask (
      .thr  (thr),
      .req  (req),
      .pass (pass)
   );

   prio_pick #(.NUM_REQ(NUM_REQ), .PRIO_W(PRIO_W), .ENC(ENC)) u_pick (
      .pass (pass),
      .any  (any_c),
      .cls  (cls_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         class_q <= '0;
      end else begin
         valid_q <= any_c;
         class_q <= cls_c;
      end
   end

   assign irq_valid = valid_q;
   assign irq_class = class_q;

   // R1: state after reset
   p_reset_state_r1: assert property (@(posedge clk)
      $past(rst) |-> (thr == '0 && !irq_valid && irq_class == '0 && !wr_err));

   // R4: a reported class sits above the threshold of the previous cycle
   p_above_thr_r4: assert property (@(posedge clk) disable iff (rst)
      irq_valid |-> irq_class > $past(thr));

   // R6: full threshold blocks the next decision
   p_block_all_r6: assert property (@(posedge clk) disable iff (rst)
      (thr == THR_MAX) |=> !irq_valid);

   // R7: no class is shown without valid
   p_idle_class_r7: assert property (@(posedge clk) disable iff (rst)
      !irq_valid |-> irq_class == '0);

   // R8: a request lacking the previous cycle yields no valid output
   p_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
      (req == '0) |=> !irq_valid);
endmodule

// File: tb/test_irq_prio_gate.sv
`timescale 1ns/1ps
module test_irq_prio_gate;
   localparam int REG_W = 64;
   localparam int NREQ  = 15;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             wr_en = 1'b0;
   logic [REG_W-1:0] wr_data = '0;
   logic [REG_W-1:0] rd_data;
   logic             wr_err;
   logic [NREQ-1:0]  req = '0;
   logic             irq_valid;
   logic [3:0]       irq_class;

   always #2 clk = ~clk;

   irq_prio_gate i_irq_prio_gate (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .wr_err(wr_err), .req(req),
      .irq_valid(irq_valid), .irq_class(irq_class)
   );

   int    checks = 0;
   int    fails  = 0;
   int    m_thr  = 0;
   bit    e_valid = 0;
   int    e_class = 0;
   bit    e_err   = 0;
   string tag = "R1";

   // behavioural reference, evaluated on inputs present at the edge
   always @(posedge clk) begin
      if (rst) begin
         m_thr = 0; e_valid = 0; e_class = 0; e_err = 0;
      end else begin
         e_valid = 0; e_class = 0;
         for (int i = 0; i < NREQ; i++)
            if (req[i] && (i + 1) > m_thr) begin e_valid = 1; e_class = i + 1; end
         e_err = wr_en && (wr_data[REG_W-1:4] != 0);
         if (wr_en && !e_err) m_thr = int'(wr_data[3:0]);
      end
   end

   task automatic check(bit ok, string req_tag, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req_tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      check(irq_valid == e_valid, tag, "irq_valid", irq_valid, e_valid);
      check(int'(irq_class) == e_class, tag, "irq_class", irq_class, e_class);
      check(wr_err == e_err, "R9/R3", "wr_err", wr_err, e_err);
      check(rd_data == longint'(m_thr), "R2", "rd_data", rd_data, m_thr);
   endtask

   task automatic cyc(bit we, logic [REG_W-1:0] d, logic [NREQ-1:0] r);
      wr_en = we; wr_data = d; req = r;
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      req = '1;
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset even with every line asserted
      check(irq_valid == 0 && irq_class == 0, "R1", "reset out", irq_class, 0);
      check(rd_data == 0 && wr_err == 0, "R1", "reset reg", rd_data, 0);
      rst = 1'b0; req = '0;
      @(negedge clk);
      check(irq_valid == 0 && rd_data == 0, "R1", "first cycle", irq_valid, 0);

      tag = "R5";
      cyc(0, 0, '1);
      check(irq_valid && irq_class == 15, "R5", "all lines thr0", irq_class, 15);
      cyc(0, 0, 15'h0001);
      check(irq_valid && irq_class == 1, "R5", "class1 thr0", irq_class, 1);

      tag = "R2";
      cyc(1, 64'd9, '0);
      check(rd_data == 64'd9, "R2", "readback", rd_data, 9);

      tag = "R4";
      cyc(0, 0, 15'h0100);
      check(!irq_valid, "R4", "class9 blocked at thr9", irq_valid, 0);
      cyc(0, 0, 15'h0200);
      check(irq_valid && irq_class == 10, "R4", "class10 passes thr9", irq_class, 10);
      cyc(0, 0, 15'h0300);
      check(irq_class == 10, "R7", "highest of 9,10", irq_class, 10);

      tag = "R8";
      cyc(1, 64'd12, 15'h0400);
      check(irq_valid && irq_class == 11, "R8", "old thr used", irq_class, 11);
      cyc(0, 0, 15'h0400);
      check(!irq_valid, "R8", "new thr used", irq_valid, 0);

      tag = "R6";
      cyc(1, 64'd15, '1);
      cyc(0, 0, '1);
      check(!irq_valid, "R6", "thr15 blocks all", irq_valid, 0);

      tag = "R3";
      cyc(1, 64'h0000_0100_0000_0003, '1);
      check(wr_err == 1, "R3", "flag raised", wr_err, 1);
      check(rd_data == 64'd15, "R3", "thr kept", rd_data, 15);
      cyc(0, 0, '1);
      check(wr_err == 0, "R9", "flag one cycle", wr_err, 0);
      check(!irq_valid, "R3", "still blocked", irq_valid, 0);

      tag = "R7";
      for (int k = 0; k < 400; k++) begin
         logic [REG_W-1:0] d;
         bit we;
         we = ($urandom % 5) == 0;
         d = {60'd0, 4'($urandom)};
         if (($urandom % 4) == 0) d[4 + ($urandom % 60)] = 1'b1;
         cyc(we, d, NREQ'($urandom));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule